// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block connects a clocked host to an external 512K x 8 asynchronous static RAM. The host issues single-beat read or write requests through a valid/ready handshake. The controller turns each request into active-low chip-select, write-strobe and output-gate signals, a 19-bit address and an 8-bit data path toward the memory. The data path is split into an output byte, an output-enable and an input byte, so that the pad ring can form the bidirectional pins.

Every timing limit of the memory is given as a nanosecond parameter. The controller turns each one into a clock-cycle count, rounded up, and holds each phase for at least that many cycles. When no request is pending, the memory stays deselected (standby). Between accesses both strobes return high, so the address only ever changes while the memory ignores it. During writes the controller keeps the output gate high, and it turns on its own data drivers only after the memory has had time to release the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after its release, mem_ce_no, mem_we_no and mem_oe_no are high, mem_dq_oe_o and rsp_valid_o are low, and req_ready_o is high.
- R2: While no request is presented, mem_ce_no stays high (standby) and no strobe toggles.
- R3: A written byte reads back unchanged at its address, including address 0x00000 and 0x7FFFF and the data values 0x00 and 0xFF, and a write leaves other addresses untouched.
- R4: A write holds mem_ce_no and mem_we_no low together for exactly WR_CYC cycles. WR_CYC is the largest of the rounded-up counts for write pulse, address-to-end, write cycle and release-plus-setup; it is 4 at the default 20 ns clock. mem_oe_no stays high for the whole write.
- R5: mem_dq_oe_o rises only once the write window is at least WHZ_CYC cycles old (2 by default). It is high for at least DW_CYC cycles (2 by default) before mem_we_no rises, stays high with unchanged data for one cycle after mem_we_no rises, and is never high while mem_oe_no is low.
- R6: A read holds mem_ce_no and mem_oe_no low with mem_we_no high for RD_CYC cycles (3 by default). rsp_valid_o is then high for exactly one cycle, RD_CYC+1 cycles after the accepting clock edge, and rsp_rdata_o carries the stored byte.
- R7: mem_addr_o never changes while mem_ce_no is low.
- R8: req_ready_o is high only while every strobe is high, and mem_ce_no stays high for at least two cycles between any two accesses.
- R9: req_we_i, req_addr_i and req_wdata_i are ignored while req_ready_o is low. Changing them during a transfer alters neither the location written nor the byte stored.
- R10: With req_valid_i held high, a write followed by a read of the same address returns the new byte, and a read followed by a write completes. In both orders the bus sees no contention and no address change under an active strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 8 | Read byte |
| mem_addr_o | output | 19 | Address to the memory |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output gate, active low |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Byte returned by the memory |

## Verification
The bench carries a memory model. It returns a poison byte until the read strobes have been low for the full access count, and it commits a write only when the data was driven long enough before the strobe ended. A controller that shortened the read or the data window would therefore store or return the wrong byte. Back-to-back write-to-read and read-to-write sequences with the request held high target turnaround. Here a design that reused the idle step or released its drivers late would show bus contention, an address moving under a low select, or a missing gap between accesses. Request fields toggled mid-transfer expose a design that samples the host outside the handshake, since it would write the wrong location or byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WRITE, ST_READ, ST_RECOVER
  } seq_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WR_CYC    = 4,
  parameter int RD_CYC    = 3,
  parameter int DRV_START = 2,
  parameter int CNT_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             op_we_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             accept_o,
  output logic             cnt_run_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             ce_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             drv_en_o
);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_AT  = CNT_W'(DRV_START);

  seq_state_e state_q, state_d;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = req_valid_i && ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP:   state_d = op_we_i ? ST_WRITE : ST_READ;
      ST_WRITE:   if (cnt_i == WR_LAST) state_d = ST_RECOVER;
      ST_READ:    if (cnt_i == RD_LAST) state_d = ST_RECOVER;
      ST_RECOVER: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // strobes decode from the registered state only
  assign cnt_run_o = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign capture_o = (state_q == ST_READ) && (cnt_i == RD_LAST);
  assign ce_no     = !cnt_run_o;
  assign we_no     = (state_q != ST_WRITE);
  assign oe_no     = (state_q != ST_READ);
  // drive once the memory has released the bus; hold one cycle past the strobe
  assign drv_en_o  = ((state_q == ST_WRITE) && (cnt_i >= DRV_AT)) ||
                     ((state_q == ST_RECOVER) && op_we_i);
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              op_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  logic              op_we_q, rsp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_we_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      op_we_q <= req_we_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= capture_i;
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  assign op_we_o     = op_we_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_AW_NS       = 50,
  parameter int T_DW_NS       = 25,
  parameter int T_WHZ_NS      = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int WHZ_CYC = ns_to_cyc(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int DW_CYC  = max2(ns_to_cyc(T_DW_NS, CLK_PERIOD_NS), 1);
  localparam int WR_CYC  = max2(max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)),
                                max2(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS),
                                     WHZ_CYC + DW_CYC));
  localparam int RD_CYC  = max2(max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                                max2(ns_to_cyc(T_OE_NS, CLK_PERIOD_NS), 1));
  localparam int CNT_W   = $clog2(max2(WR_CYC, RD_CYC) + 1);

  logic             accept, capture, cnt_run, op_we;
  logic [CNT_W-1:0] cnt;

  sram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (cnt_run),
    .cnt_o (cnt)
  );

  sram_seq #(
    .WR_CYC   (WR_CYC),
    .RD_CYC   (RD_CYC),
    .DRV_START(WHZ_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .op_we_i    (op_we),
    .cnt_i      (cnt),
    .accept_o   (accept),
    .cnt_run_o  (cnt_run),
    .capture_o  (capture),
    .ready_o    (req_ready_o),
    .ce_no      (mem_ce_no),
    .we_no      (mem_we_no),
    .oe_no      (mem_oe_no),
    .drv_en_o   (mem_dq_oe_o)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .req_we_i   (req_we_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .mem_dq_i   (mem_dq_i),
    .op_we_o    (op_we),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_dq_oe_o
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (mem_ce_no && mem_we_no && mem_oe_no && !mem_dq_oe_o && !rsp_valid_o));

  p_we_inside_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no));

  p_no_contention_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  p_drive_after_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (!mem_we_no && !$past(mem_we_no)));

  p_rsp_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !$past(mem_ce_no)) |-> $stable(mem_addr_o));

  p_ready_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && mem_we_no && mem_oe_no));

  p_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |=> mem_ce_no);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_addr_o (mem_addr_o),
  .mem_ce_no  (mem_ce_no),
  .mem_we_no  (mem_we_no),
  .mem_oe_no  (mem_oe_no),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int WR_B  = 4;  // max(ceil 45/20, ceil 50/20, ceil 55/20, 2+2)
  localparam int RD_B  = 3;  // ceil 55/20
  localparam int WHZ_B = 2;  // ceil 30/20
  localparam int DW_B  = 2;  // ceil 25/20

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rsp_rdata, dq_out;
  logic [7:0]  dq_in = 8'hEE;
  logic [18:0] mem_addr;

  int n_chk = 0, n_bad = 0, cyc = 0, t_acc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_async_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_addr_o(mem_addr),
    .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
  );

  // memory model, evaluated at the falling edge
  logic [7:0]  mem_m [logic [18:0]];
  logic [18:0] ov_addr = '0, prev_addr = '0;
  logic [7:0]  wdat = '0;
  int rd_age = 0, ov_len = 0, drv_len = 0, drv_start = 0;
  int last_pulse = 0, last_drv = 0, last_start = 0, last_hold = 0;
  int cont = 0, addr_viol = 0, oe_in_wr = 0, gap = 0, min_gap = 1000, seen = 0;
  bit prev_ce_low = 1'b0;

  function automatic logic [7:0] mem_rd(input logic [18:0] a);
    return mem_m.exists(a) ? mem_m[a] : 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (!ce_n && we_n && !oe_n) rd_age = rd_age + 1; else rd_age = 0;
    dq_in = (rd_age >= RD_B) ? mem_rd(mem_addr) : 8'hEE;
    if (dq_oe && !oe_n) cont++;
    if (!ce_n && prev_ce_low && mem_addr != prev_addr) addr_viol++;
    prev_ce_low = !ce_n;
    prev_addr   = mem_addr;
    if (ce_n) gap++;
    else begin
      if (seen != 0 && gap > 0 && gap < min_gap) min_gap = gap;
      gap = 0;
      seen = 1;
    end
    if (!ce_n && !we_n) begin
      if (ov_len == 0) ov_addr = mem_addr;
      ov_len++;
      if (!oe_n) oe_in_wr++;
      if (dq_oe) begin
        if (drv_len == 0) drv_start = ov_len - 1;
        drv_len++;
        wdat = dq_out;
      end
    end else if (ov_len > 0) begin
      last_pulse = ov_len;
      last_drv   = drv_len;
      last_start = drv_start;
      last_hold  = (dq_oe && dq_out == wdat) ? 1 : 0;
      if (drv_len >= DW_B) mem_m[ov_addr] = wdat;
      ov_len = 0;
      drv_len = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit we, input logic [18:0] a, input logic [7:0] d);
    req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
    t_acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
  endtask

  task automatic get_rsp(output logic [7:0] d, output int lat);
    for (int i = 0; i < 100 && !rsp_valid; i++) @(negedge clk);
    lat = cyc - t_acc;
    d = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R6 pulse width", int'(rsp_valid), 0);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    wait_idle();
  endtask

  task automatic do_read(input logic [18:0] a, output logic [7:0] d, output int lat);
    issue(1'b0, a, 8'h00);
    get_rsp(d, lat);
    wait_idle();
  endtask

  task automatic t_reset();
    chk(ce_n && we_n && oe_n, "R1 strobes in reset", {ce_n, we_n, oe_n}, 7);
    chk(!dq_oe && !rsp_valid, "R1 drivers/rsp in reset", {dq_oe, rsp_valid}, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(req_ready && ce_n && we_n && oe_n && !dq_oe, "R1 after release",
        {req_ready, ce_n, we_n, oe_n, dq_oe}, 5'b11110);
  endtask

  task automatic t_idle();
    int lows = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!ce_n || !we_n || !oe_n) lows++;
    end
    chk(lows == 0, "R2 standby when idle", lows, 0);
  endtask

  task automatic t_write_read_basic();
    logic [7:0] d; int lat;
    do_write(19'h12345, 8'hA5);
    chk(last_pulse == WR_B, "R4 write window length", last_pulse, WR_B);
    chk(oe_in_wr == 0, "R4 oe high during write", oe_in_wr, 0);
    chk(last_start >= WHZ_B, "R5 driver start", last_start, WHZ_B);
    chk(last_drv >= DW_B, "R5 data setup", last_drv, DW_B);
    chk(last_hold == 1, "R5 data hold after strobe", last_hold, 1);
    do_read(19'h12345, d, lat);
    chk(d == 8'hA5, "R3 readback", d, 8'hA5);
    chk(lat == RD_B + 1, "R6 read latency", lat, RD_B + 1);
  endtask

  task automatic t_patterns();
    logic [7:0] d; int lat;
    do_write(19'h00000, 8'h00);
    do_write(19'h7FFFF, 8'hFF);
    do_write(19'h2AAAA, 8'h3C);
    do_read(19'h00000, d, lat); chk(d == 8'h00, "R3 addr 0", d, 8'h00);
    do_read(19'h7FFFF, d, lat); chk(d == 8'hFF, "R3 top addr", d, 8'hFF);
    do_read(19'h2AAAA, d, lat); chk(d == 8'h3C, "R3 mid addr", d, 8'h3C);
    chk(lat == RD_B + 1, "R6 latency again", lat, RD_B + 1);
    do_read(19'h12345, d, lat); chk(d == 8'hA5, "R3 untouched neighbour", d, 8'hA5);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d; int lat;
    do_write(19'h01111, 8'h11);
    issue(1'b1, 19'h00777, 8'h77);
    req_we = 1'b0; req_addr = 19'h01111; req_wdata = 8'h99;  // toggled while busy
    chk(!req_ready, "R8 ready low while busy", int'(req_ready), 0);
    wait_idle();
    do_read(19'h00777, d, lat); chk(d == 8'h77, "R9 target write intact", d, 8'h77);
    do_read(19'h01111, d, lat); chk(d == 8'h11, "R9 other addr intact", d, 8'h11);
  endtask

  task automatic t_back_to_back();
    logic [7:0] d; int lat;
    issue(1'b1, 19'h05050, 8'hC3);
    issue(1'b0, 19'h05050, 8'h00);
    get_rsp(d, lat);
    chk(d == 8'hC3, "R10 write then read", d, 8'hC3);
    issue(1'b0, 19'h7FFFF, 8'h00);
    issue(1'b1, 19'h06060, 8'h5C);
    wait_idle();
    @(negedge clk);
    do_read(19'h06060, d, lat);
    chk(d == 8'h5C, "R10 read then write", d, 8'h5C);
    chk(cont == 0, "R10 bus contention", cont, 0);
    chk(addr_viol == 0, "R7 address moved under select", addr_viol, 0);
    chk(min_gap >= 2, "R8 gap between accesses", min_gap, 2);
  endtask

  initial begin
    #1;
    t_reset();
    t_idle();
    t_write_read_basic();
    t_patterns();
    t_busy_ignore();
    t_back_to_back();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule